// File: doc/BRIEF.md
# I2C Register-Table Configuration Sequencer

This block brings up an external device over I2C by walking a fixed table of register writes. Each table word is 24 bits: the device write address, the register index and the data byte. The sequencer hands one word at a time to a byte-level I2C write engine over a simple GO/payload/done/NACK handshake. The serial bit timing is left to that engine. The sequencer also produces the engine's timing enable: one pulse every CLK_FREQ/I2C_FREQ system clocks. Its own state machine advances only on that pulse. Because both frequencies are parameters, the divider can be shrunk to a couple of cycles for simulation.

When every table word has been written, the table index steps once past the last entry, to the table size, and READY goes high. An active-low interrupt input is resynchronised by two flops. While its synchronised value is low, the walk is held at index 0 with READY and GO low. This applies whether the walk was finished or still in progress. Once the interrupt is released, the whole table is written again.

An attempt the engine reports as not acknowledged is retried on the same entry. A watchdog counts consecutive unacknowledged attempts and clears that count on every acknowledged one. When the count reaches NACK_LIMIT, the watchdog latches ERROR, which only reset clears. The walk itself carries on retrying, so a device that recovers still gets configured.

Top module: `cfg_table_seq`

## Requirements
- R1: While rst_n is low, ready, error and go are 0 and tbl_index is 0.
- R2: Table word e (0-based) is {8'h72, reg, data}, where reg = (3*e+1) mod 256 and data = ((29*e) mod 256) XOR 8'hA5. Bits 23:16 hold the device write address 8'h72, which is the 7-bit address 0x39 with the R/W bit at 0. Every transaction attempt is one rising edge of go. At that edge, payload holds the word of the entry named by tbl_index. Payload stays stable while go is high.
- R3: With every attempt acknowledged, the attempts visit entries 0 to TABLE_SIZE-1 in order, once each. tbl_index then reads TABLE_SIZE and ready is high. ready is never high with tbl_index different from TABLE_SIZE.
- R4: An attempt that ends with xfer_done high and nack high is retried. The next go rise carries the same tbl_index and payload.
- R5: error goes high once NACK_LIMIT consecutive attempts have been unacknowledged (default 16). With NACK_LIMIT-1 or fewer, error stays low, and it stays low through a walk in which every attempt is acknowledged.
- R6: An acknowledged attempt clears the consecutive count. NACK_LIMIT-1 unacknowledged attempts on one entry, followed by an acknowledgement and NACK_LIMIT-1 more on the next entry, leave error low.
- R7: Once high, error stays high through further acknowledgements and interrupt-triggered walks until reset.
- R8: When int_n is low, the sequencer is held in restart within three clocks: tbl_index is 0, and ready and go are low. After release, the full table is walked again from entry 0 and ready rises again.
- R9: int_n low during an unfinished walk restarts that walk from entry 0.
- R10: eng_tick pulses for one clock every CLK_FREQ/I2C_FREQ clocks (every clock when the ratio is 1). go, payload and tbl_index change only on those clocks, or on restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_n | input | 1 | Active-low re-initialisation request, asynchronous |
| eng_tick | output | 1 | Timing enable for the write engine, one clock wide |
| ready | output | 1 | High when the whole table has been written |
| error | output | 1 | Sticky consecutive-NACK watchdog flag |
| tbl_index | output | $clog2(TABLE_SIZE+1) | Current table entry, TABLE_SIZE once finished |
| go | output | 1 | Transaction request, held until the engine reports done |
| payload | output | 24 | {device address, register, data} of the current entry |
| xfer_done | input | 1 | Engine finished the attempt; held until go falls |
| nack | input | 1 | Valid with xfer_done: 1 = attempt not acknowledged |

## Verification
A vector table runs a complete walk under several NACK injection patterns, with a fresh reset before each one. The patterns are: none at all; a few on one entry; NACK_LIMIT-1 on the last entry; exactly NACK_LIMIT; and more than NACK_LIMIT on the first entry. Each vector's full list of attempts (index and payload) is compared with the list expected from the injection plan. This separates a correct retry from skipping or duplicating an entry, and it places the error threshold exactly. Split runs of NACK_LIMIT-1 on two neighbouring entries confirm that an acknowledgement clears the count. Interrupts applied after completion and in the middle of a walk confirm that the walk restarts from entry 0 and that the sticky error survives until reset.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  localparam logic [7:0] DEV_WADDR = 8'h72;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_WAIT = 2'd1,
    ST_NEXT = 2'd2
  } seq_st_t;

  // Table content is computed, not stored.
  function automatic logic [23:0] entry_word(input int unsigned e);
    logic [7:0] reg_idx;
    logic [7:0] dat;
    reg_idx = 8'(e * 3 + 1);
    dat     = 8'(e * 29) ^ 8'hA5;
    return {DEV_WADDR, reg_idx, dat};
  endfunction

endpackage

// File: rtl/cfgseq_tick.sv
module cfgseq_tick #(
  parameter int DIV = 2500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/cfgseq_sync2.sv
module cfgseq_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/cfgseq_nackdog.sv
module cfgseq_nackdog #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_ack,
  input  logic ev_nack,
  output logic error
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          en;

  assign en = ev_ack | ev_nack;

  always_comb begin
    cnt_d = cnt_q;
    if (ev_ack)                        cnt_d = '0;
    else if (ev_nack && cnt_q != TOP)  cnt_d = cnt_q + CW'(1);
    err_d = err_q | (cnt_d == TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign error = err_q;
endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfgseq_pkg::*;
#(
  parameter int TABLE_SIZE = 38,
  parameter int IW = $clog2(TABLE_SIZE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          xfer_done,
  input  logic          nack,
  output logic          go,
  output logic [23:0]   payload,
  output logic [IW-1:0] tbl_index,
  output logic          ready,
  output logic          ev_ack,
  output logic          ev_nack
);
  localparam logic [IW-1:0] END_IDX = IW'(TABLE_SIZE);

  seq_st_t       st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          go_q, go_d;
  logic          rdy_q, rdy_d;
  logic [23:0]   pl_q, pl_d;
  logic          en;

  assign en = restart | tick;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    go_d    = go_q;
    rdy_d   = rdy_q;
    pl_d    = pl_q;
    ev_ack  = 1'b0;
    ev_nack = 1'b0;
    if (restart) begin
      st_d  = ST_LOAD;
      idx_d = '0;
      go_d  = 1'b0;
      rdy_d = 1'b0;
    end else if (tick) begin
      unique case (st_q)
        ST_LOAD: begin
          if (idx_q == END_IDX) begin
            rdy_d = 1'b1;
          end else begin
            pl_d = entry_word(int'(idx_q));
            go_d = 1'b1;
            st_d = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (xfer_done) begin
            go_d = 1'b0;
            if (!nack) begin
              ev_ack = 1'b1;
              st_d   = ST_NEXT;
            end else begin
              ev_nack = 1'b1;
              st_d    = ST_LOAD;
            end
          end
        end
        ST_NEXT: begin
          idx_d = idx_q + IW'(1);
          st_d  = ST_LOAD;
        end
        default: st_d = ST_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LOAD;
      idx_q <= '0;
      go_q  <= 1'b0;
      rdy_q <= 1'b0;
      pl_q  <= '0;
    end else if (en) begin
      st_q  <= st_d;
      idx_q <= idx_d;
      go_q  <= go_d;
      rdy_q <= rdy_d;
      pl_q  <= pl_d;
    end
  end

  assign go        = go_q;
  assign payload   = pl_q;
  assign tbl_index = idx_q;
  assign ready     = rdy_q;
endmodule

// File: rtl/cfg_table_seq.sv
module cfg_table_seq #(
  parameter int CLK_FREQ   = 50_000_000,
  parameter int I2C_FREQ   = 20_000,
  parameter int TABLE_SIZE = 38,
  parameter int NACK_LIMIT = 16,
  localparam int IW        = $clog2(TABLE_SIZE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_n,
  output logic          eng_tick,
  output logic          ready,
  output logic          error,
  output logic [IW-1:0] tbl_index,
  output logic          go,
  output logic [23:0]   payload,
  input  logic          xfer_done,
  input  logic          nack
);
  localparam int DIV = CLK_FREQ / I2C_FREQ;

  logic int_s;
  logic restart;
  logic ev_ack, ev_nack;

  cfgseq_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(eng_tick)
  );

  cfgseq_sync2 u_sync (
    .clk(clk), .rst_n(rst_n), .d(int_n), .q(int_s)
  );

  assign restart = ~int_s;

  cfgseq_fsm #(.TABLE_SIZE(TABLE_SIZE), .IW(IW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(eng_tick), .restart(restart),
    .xfer_done(xfer_done), .nack(nack), .go(go), .payload(payload),
    .tbl_index(tbl_index), .ready(ready), .ev_ack(ev_ack), .ev_nack(ev_nack)
  );

  cfgseq_nackdog #(.LIMIT(NACK_LIMIT)) u_dog (
    .clk(clk), .rst_n(rst_n), .ev_ack(ev_ack), .ev_nack(ev_nack), .error(error)
  );
endmodule

// File: rtl/cfg_table_seq_chk.sv
module cfg_table_seq_chk #(
  parameter int TABLE_SIZE = 38,
  parameter int IW = 6,
  parameter int TICK_DIV = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          restart,
  input logic          ready,
  input logic          error,
  input logic [IW-1:0] tbl_index,
  input logic          go,
  input logic [23:0]   payload,
  input logic          xfer_done
);
  AST_GO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !xfer_done && !restart) |=> go);                                  // R2
  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go)) |-> $stable(payload));                                  // R2
  AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (tbl_index == IW'(TABLE_SIZE)));                                 // R3
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_index != $past(tbl_index)) |->
      (tbl_index == $past(tbl_index) + IW'(1) || tbl_index == '0));           // R3
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);                                                          // R7
  AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tbl_index == '0 && !ready && !go));                           // R8
  AST_GO_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (go != $past(go)) |-> ($past(tick) || $past(restart)));                    // R10

  generate
    if (TICK_DIV > 1) begin : g_gap
      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                                       // R10
    end
  endgenerate
endmodule

bind cfg_table_seq cfg_table_seq_chk #(
  .TABLE_SIZE(TABLE_SIZE), .IW(IW), .TICK_DIV(CLK_FREQ / I2C_FREQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(eng_tick), .restart(restart),
  .ready(ready), .error(error), .tbl_index(tbl_index), .go(go),
  .payload(payload), .xfer_done(xfer_done)
);

// File: tb/cfg_table_seq_bench.sv
`timescale 1ns/1ps
module cfg_table_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SZ   = 38;
  localparam int LIM  = 16;
  localparam int IW   = $clog2(SZ + 1);
  localparam int LAT  = 3;
  localparam int RING = 1024;
  localparam int NV   = 5;
  // vector: {entry, nack count, expected error}
  localparam int VEC [NV][3] = '{
    '{0,  0,  0},
    '{5,  3,  0},
    '{37, 15, 0},
    '{10, 16, 1},
    '{0,  18, 1}
  };

  logic clk = 1'b0;
  logic rst_n, int_n;
  logic eng_tick, ready, error, go, xfer_done, nack;
  logic [IW-1:0] tbl_index;
  logic [23:0] payload;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_table_seq #(.CLK_FREQ(2), .I2C_FREQ(1), .TABLE_SIZE(SZ), .NACK_LIMIT(LIM))
  u_cfg_table_seq (
    .clk(clk), .rst_n(rst_n), .int_n(int_n), .eng_tick(eng_tick),
    .ready(ready), .error(error), .tbl_index(tbl_index), .go(go),
    .payload(payload), .xfer_done(xfer_done), .nack(nack)
  );

  int checks = 0;
  int fails  = 0;
  int plan [0:SZ-1];
  int used [0:SZ-1];
  int att_idx [0:RING-1];
  logic [23:0] att_pl [0:RING-1];
  int n_att = 0;
  int cyc = 0;
  int eng_cnt;
  logic go_d;

  function automatic logic [23:0] exp_word(input int e);
    return {8'h72, 8'(3 * e + 1), 8'(29 * e) ^ 8'hA5};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Write-engine model and attempt monitor, both away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      xfer_done = 1'b0;
      nack = 1'b0;
      eng_cnt = 0;
      go_d = 1'b0;
      for (int i = 0; i < SZ; i++) used[i] = 0;
    end else begin
      if (go && !go_d) begin
        att_idx[n_att % RING] = int'(tbl_index);
        att_pl[n_att % RING]  = payload;
        n_att++;
      end
      go_d = go;
      if (!go) begin
        xfer_done = 1'b0;
        eng_cnt = 0;
      end else if (!xfer_done) begin
        if (eng_cnt == LAT) begin
          xfer_done = 1'b1;
          if (int'(tbl_index) < SZ && used[tbl_index] < plan[tbl_index]) begin
            nack = 1'b1;
            used[tbl_index]++;
          end else begin
            nack = 1'b0;
          end
          eng_cnt = 0;
        end else begin
          eng_cnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic clear_plan();
    for (int i = 0; i < SZ; i++) plan[i] = 0;
  endtask

  task automatic do_reset(input bit check_state);
    @(negedge clk);
    rst_n = 1'b0;
    int_n = 1'b1;
    repeat (3) @(negedge clk);
    if (check_state) begin
      check(!ready && !error && !go, "R1 flags in reset", {ready, error, go}, 0);
      check(tbl_index == '0, "R1 index in reset", int'(tbl_index), 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic wait_ready(input string tag, output bit ok);
    int t = 0;
    ok = 1'b0;
    while (t < 20000) begin
      @(negedge clk);
      t++;
      if (ready) begin ok = 1'b1; break; end
    end
    check(ok, tag, int'(ok), 1);
  endtask

  // Compare attempts from base against the sequence implied by plan.
  task automatic check_walk(input int base, input string tag);
    int k = base;
    int bad = 0;
    int bad_k = -1;
    for (int e = 0; e < SZ; e++) begin
      for (int r = 0; r <= plan[e]; r++) begin
        if (k < n_att && bad == 0 &&
            (att_idx[k % RING] != e || att_pl[k % RING] != exp_word(e))) begin
          bad = 1;
          bad_k = k - base;
        end
        k++;
      end
    end
    check(bad == 0, {tag, " attempt order/payload, first bad slot"}, bad_k, -1);
    check(n_att - base == k - base, {tag, " attempt count"}, n_att - base, k - base);
  endtask

  initial begin
    bit ok;
    int base;
    int t0, t1;
    rst_n = 1'b0;
    int_n = 1'b1;
    clear_plan();

    // Vector loop: R2 R3 R4 R5 under varied NACK injection.
    for (int v = 0; v < NV; v++) begin
      clear_plan();
      plan[VEC[v][0]] = VEC[v][1];
      do_reset(v == 0);
      base = n_att;
      wait_ready($sformatf("R3 ready after walk, vector %0d", v), ok);
      check(int'(tbl_index) == SZ, $sformatf("R3 final index, vector %0d", v),
            int'(tbl_index), SZ);
      check_walk(base, $sformatf("R2 R4 vector %0d", v));
      check(error == VEC[v][2][0], $sformatf("R5 error level, vector %0d", v),
            int'(error), VEC[v][2]);
    end

    // R10: tick spacing.
    @(negedge clk);
    while (!eng_tick) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    while (!eng_tick) @(negedge clk);
    t1 = cyc;
    check(t1 - t0 == 2, "R10 tick period", t1 - t0, 2);

    // R7: error stays high through an interrupt-triggered rewalk.
    clear_plan();
    @(negedge clk);
    int_n = 1'b0;
    repeat (4) @(negedge clk);
    int_n = 1'b1;
    wait_ready("R7 rewalk ready", ok);
    check(error, "R7 error sticky after acked rewalk", int'(error), 1);

    // R6: consecutive count clears on ACK.
    clear_plan();
    plan[3] = LIM - 1;
    plan[4] = LIM - 1;
    do_reset(1'b0);
    check(!error, "R7 reset clears error", int'(error), 0);
    base = n_att;
    wait_ready("R6 walk ready", ok);
    check(!error, "R6 split nack runs leave error low", int'(error), 0);
    check_walk(base, "R6");

    // R8: interrupt after completion.
    clear_plan();
    @(negedge clk);
    int_n = 1'b0;
    repeat (3) @(negedge clk);
    check(tbl_index == '0 && !ready && !go, "R8 held in restart",
          int'(tbl_index) + 100 * int'(ready), 0);
    @(negedge clk);
    base = n_att;
    int_n = 1'b1;
    wait_ready("R8 ready after rewalk", ok);
    check_walk(base, "R8 rewalk");

    // R9: interrupt during an unfinished walk.
    do_reset(1'b0);
    ok = 1'b0;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (int'(tbl_index) == 10) begin ok = 1'b1; break; end
    end
    check(ok, "R9 walk reached entry 10", int'(tbl_index), 10);
    int_n = 1'b0;
    repeat (3) @(negedge clk);
    check(tbl_index == '0 && !go, "R9 mid-walk index back to 0", int'(tbl_index), 0);
    base = n_att;
    int_n = 1'b1;
    wait_ready("R9 ready after restarted walk", ok);
    check_walk(base, "R9 restarted walk");
    check(!error, "R5 no error on acked walks", int'(error), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule